// File: doc/BRIEF.md
# Shared Receive Character Silo

This block gathers characters from a group of serial receivers into one shared queue and hands them to a processor through a single read-only buffer word. Each stored entry carries the received character, the number of the line it came from, and three error flags (overrun, framing, parity). Reading the buffer word returns the oldest entry and removes it from the queue in the same access.

A separate alarm counter counts every character written into the queue, with no regard to how full the queue is, and raises an alarm flag on each sixteenth write. With the alarm enabled, the processor is interrupted once per batch instead of once per character. The block also produces the receiver-done status and the receiver interrupt request. The receivers, their bit timing and the bus address decode live elsewhere; the control bits (scan enable, alarm enable, receiver interrupt enable) arrive as plain inputs.

Top module: `rx_silo`

## Requirements
- R1: `rd_data` is laid out as: bit 15 valid (queue not empty), bit 14 overrun, bit 13 framing error, bit 12 parity error, bit 11 zero, bits 10:8 line number, bits 7:0 character; every field except bit 15 comes from the queue head.
- R2: While the queue is empty, `rd_data` is all zeros and a read strobe leaves the queue unchanged, so a later character reads back normally.
- R3: A read strobe on a non-empty queue removes the head at that clock edge; entries come out in the order they were written.
- R4: A receiver's character is taken only while `scan_en` is high; a taken character is signalled by that line's bit of `rx_ack` in the cycle the clock edge stores it.
- R5: At most one character is stored per cycle; among lines presenting at once, the lowest-numbered line is acknowledged and the others wait.
- R6: A character arriving while the queue is full (and not being read) replaces the most recently written entry, and that entry's overrun bit (bit 14) is set; depth never exceeds `DEPTH`.
- R7: `alarm` rises on the clock edge that stores the sixteenth character since the alarm was last cleared, independent of queue occupancy.
- R8: `alarm` and its counter are cleared by a read strobe, by `alarm_en` low, by `ctrl_clr` or by `bus_init`; a character stored in a clearing cycle is not counted, and the alarm rises again only after sixteen further characters.
- R9: `rx_done` is high exactly when the queue holds at least one entry.
- R10: `rx_irq` equals `rie` AND (`alarm` if `alarm_en` is high, else `rx_done`).
- R11: `ctrl_clr` or `bus_init` empties the queue at the next clock edge and clears the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_init | input | 1 | Synchronous bus initialise, empties queue |
| ctrl_clr | input | 1 | Synchronous controller clear, empties queue |
| scan_en | input | 1 | Master scan enable, gates character acceptance |
| alarm_en | input | 1 | Batch alarm enable |
| rie | input | 1 | Receiver interrupt enable |
| rx_valid | input | NUM_LINES | Per-line character present |
| rx_char | input | NUM_LINES*8 | Per-line characters, line n in bits 8n+7:8n |
| rx_frm | input | NUM_LINES | Per-line framing error flag |
| rx_par | input | NUM_LINES | Per-line parity error flag |
| rx_ack | output | NUM_LINES | One-hot acknowledge of the stored line |
| rd_stb | input | 1 | Buffer read strobe (pops on non-empty) |
| rd_data | output | 16 | Buffer read word |
| rx_done | output | 1 | Queue not empty |
| alarm | output | 1 | Batch alarm flag |
| rx_irq | output | 1 | Receiver interrupt request |

## Verification
A pointer or count error inside the queue shows up at the next read as a wrong character, wrong line or a missing valid bit, so every check reads the buffer word straight after the edge that should have changed it. A wrong alarm count is visible only at the sixteenth write, so the alarm tests step up to the fifteenth and sixteenth characters and look at `alarm` on each side. Overrun errors surface only at the last entry of a full queue, so the full-queue test drains all entries and compares each one.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int LINE_W = 3;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              ovr;
    logic              frm;
    logic              par;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rx_entry_t;

  // Buffer word: valid, overrun, framing, parity, zero, line, character
  function automatic logic [15:0] rbuf_word(input logic valid, input rx_entry_t e);
    return valid ? {1'b1, e.ovr, e.frm, e.par, 1'b0, e.line, e.ch} : 16'h0000;
  endfunction
endpackage

// File: rtl/rx_silo_arb.sv
module rx_silo_arb
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [NUM_LINES-1:0] req,
  output logic [NUM_LINES-1:0] grant,
  output logic                 any,
  output logic [LINE_W-1:0]    idx
);
  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_pri
      if (g == 0) begin : g_first
        assign grant[g] = enable & req[g];
      end else begin : g_rest
        assign grant[g] = enable & req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  assign any = |grant;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (grant[i]) idx = LINE_W'(i);
    end
  end

  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_ack_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & (grant - 1'b1)) == '0));
  p_ack_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (grant == '0));
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t wr_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full,
  output logic      overwrite
);
  rx_entry_t        mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop_ok, push_new;
  rx_entry_t        ovw_entry;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_prev(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign pop_ok    = pop & ~empty;
  assign overwrite = push & full & ~pop_ok;
  assign push_new  = push & ~overwrite;
  assign head      = mem[rd_ptr];

  always_comb begin
    ovw_entry     = wr_entry;
    ovw_entry.ovr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (overwrite)     mem[ptr_prev(wr_ptr)] <= ovw_entry;
      else if (push_new) mem[wr_ptr]           <= wr_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_new) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)   rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(push_new) - CNT_W'(pop_ok);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_overwrite_stays_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overwrite && !flush) |=> full);
  p_push_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_new && !pop_ok && !flush) |=> (count == $past(count) + 1'b1));
  p_pop_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push && !flush) |=> (count == $past(count) - 1'b1));
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rx_silo_alarm.sv
module rx_silo_alarm #(
  parameter int THRESH = 16,
  localparam int CW    = $clog2(THRESH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic write,
  output logic alarm,
  output logic hit
);
  logic [CW-1:0] cnt;

  assign hit = write & (cnt == CW'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      alarm <= 1'b0;
    end else if (clear) begin
      cnt   <= '0;
      alarm <= 1'b0;
    end else if (write) begin
      cnt <= hit ? '0 : cnt + 1'b1;
      if (hit) alarm <= 1'b1;
    end
  end

  p_alarm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !alarm);
  p_alarm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clear) |=> alarm);
  p_alarm_only_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(hit));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 64,
  parameter int THRESH    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_init,
  input  logic                        ctrl_clr,
  input  logic                        scan_en,
  input  logic                        alarm_en,
  input  logic                        rie,
  input  logic [NUM_LINES-1:0]        rx_valid,
  input  logic [NUM_LINES*CHAR_W-1:0] rx_char,
  input  logic [NUM_LINES-1:0]        rx_frm,
  input  logic [NUM_LINES-1:0]        rx_par,
  output logic [NUM_LINES-1:0]        rx_ack,
  input  logic                        rd_stb,
  output logic [15:0]                 rd_data,
  output logic                        rx_done,
  output logic                        alarm,
  output logic                        rx_irq
);
  logic              flush, push, empty, full, overwrite, alarm_clr, alarm_hit;
  logic [LINE_W-1:0] sel;
  rx_entry_t         wr_entry, head;

  assign flush     = ctrl_clr | bus_init;
  assign alarm_clr = flush | rd_stb | ~alarm_en;

  rx_silo_arb #(.NUM_LINES(NUM_LINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .enable(scan_en & ~flush), .req(rx_valid),
    .grant(rx_ack), .any(push), .idx(sel)
  );

  always_comb begin
    wr_entry      = '0;
    wr_entry.frm  = rx_frm[sel];
    wr_entry.par  = rx_par[sel];
    wr_entry.line = sel;
    wr_entry.ch   = rx_char[sel*CHAR_W +: CHAR_W];
  end

  rx_silo_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .wr_entry(wr_entry),
    .pop(rd_stb), .head(head), .empty(empty), .full(full), .overwrite(overwrite)
  );

  rx_silo_alarm #(.THRESH(THRESH)) u_alarm (
    .clk(clk), .rst_n(rst_n), .clear(alarm_clr), .write(push),
    .alarm(alarm), .hit(alarm_hit)
  );

  assign rd_data = rbuf_word(~empty, head);
  assign rx_done = ~empty;
  assign rx_irq  = rie & (alarm_en ? alarm : rx_done);

  p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && empty && !push) |=> empty);
  p_done_after_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rd_stb) |=> rx_done);
  p_irq_needs_rie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rie && (alarm || rx_done)));
endmodule

// File: tb/rx_silo_tb.sv
module rx_silo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic            clk = 1'b0;
  logic            rst_n, bus_init, ctrl_clr, scan_en, alarm_en, rie, rd_stb;
  logic [NL-1:0]   rx_valid, rx_frm, rx_par, rx_ack;
  logic [NL*8-1:0] rx_char;
  logic [15:0]     rd_data;
  logic            rx_done, alarm, rx_irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_silo u_dut (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .ctrl_clr(ctrl_clr),
    .scan_en(scan_en), .alarm_en(alarm_en), .rie(rie), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_frm(rx_frm), .rx_par(rx_par), .rx_ack(rx_ack),
    .rd_stb(rd_stb), .rd_data(rd_data), .rx_done(rx_done), .alarm(alarm), .rx_irq(rx_irq)
  );

  function automatic logic [15:0] exp_word(logic ovr, logic frm, logic par,
                                           logic [2:0] ln, logic [7:0] ch);
    return {1'b1, ovr, frm, par, 1'b0, ln, ch};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_one(int ln, logic [7:0] ch, logic frm, logic par);
    @(negedge clk);
    rx_valid[ln] = 1'b1;
    rx_char[ln*8 +: 8] = ch;
    rx_frm[ln] = frm;
    rx_par[ln] = par;
    @(negedge clk);
    rx_valid[ln] = 1'b0;
    rx_frm[ln] = 1'b0;
    rx_par[ln] = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] w);
    @(negedge clk);
    w = rd_data;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse_clear(bit use_init);
    @(negedge clk);
    if (use_init) bus_init = 1'b1; else ctrl_clr = 1'b1;
    @(negedge clk);
    bus_init = 1'b0;
    ctrl_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 reset word", 32'(rd_data), 32'h0);
    chk("R9 reset done", 32'(rx_done), 32'h0);
    chk("R7 reset alarm", 32'(alarm), 32'h0);
    chk("R10 reset irq", 32'(rx_irq), 32'h0);
  endtask

  task automatic t_basic;
    logic [15:0] w;
    push_one(3, 8'h5A, 1'b1, 1'b0);
    chk("R9 done after store", 32'(rx_done), 32'h1);
    chk("R1 layout frm", 32'(rd_data), 32'(exp_word(0, 1, 0, 3'd3, 8'h5A)));
    push_one(6, 8'hC3, 1'b0, 1'b1);
    read_word(w);
    chk("R3 first out", 32'(w), 32'(exp_word(0, 1, 0, 3'd3, 8'h5A)));
    chk("R1 layout par", 32'(rd_data), 32'(exp_word(0, 0, 1, 3'd6, 8'hC3)));
    read_word(w);
    chk("R2 empty word zero", 32'(rd_data), 32'h0);
    chk("R9 done clears", 32'(rx_done), 32'h0);
  endtask

  task automatic t_empty_read;
    logic [15:0] w;
    read_word(w);
    chk("R2 empty read value", 32'(w), 32'h0);
    read_word(w);
    push_one(1, 8'h11, 1'b0, 1'b0);
    read_word(w);
    chk("R2 empty read no effect", 32'(w), 32'(exp_word(0, 0, 0, 3'd1, 8'h11)));
    chk("R3 empty after pop", 32'(rx_done), 32'h0);
  endtask

  task automatic t_scan_off;
    @(negedge clk);
    scan_en = 1'b0;
    rx_valid[1] = 1'b1;
    rx_char[15:8] = 8'h77;
    #1 chk("R4 no ack when scan off", 32'(rx_ack), 32'h0);
    @(negedge clk);
    chk("R4 nothing stored", 32'(rx_done), 32'h0);
    rx_valid[1] = 1'b0;
    scan_en = 1'b1;
  endtask

  task automatic t_arb;
    logic [15:0] w;
    @(negedge clk);
    rx_valid = 8'b0110_0100;
    rx_char[2*8 +: 8] = 8'h22;
    rx_char[5*8 +: 8] = 8'h55;
    rx_char[6*8 +: 8] = 8'h66;
    #1 chk("R5 lowest acked", 32'(rx_ack), 32'h04);
    @(negedge clk);
    rx_valid[2] = 1'b0;
    #1 chk("R5 next line", 32'(rx_ack), 32'h20);
    @(negedge clk);
    rx_valid[5] = 1'b0;
    #1 chk("R4 ack last", 32'(rx_ack), 32'h40);
    @(negedge clk);
    rx_valid[6] = 1'b0;
    read_word(w); chk("R5 order 1", 32'(w), 32'(exp_word(0, 0, 0, 3'd2, 8'h22)));
    read_word(w); chk("R5 order 2", 32'(w), 32'(exp_word(0, 0, 0, 3'd5, 8'h55)));
    read_word(w); chk("R5 order 3", 32'(w), 32'(exp_word(0, 0, 0, 3'd6, 8'h66)));
  endtask

  task automatic t_overflow;
    logic [15:0] w;
    int bad = 0;
    for (int i = 0; i < 64; i++) push_one(i % 8, 8'(i), 1'b0, 1'b0);
    push_one(4, 8'hA0, 1'b0, 1'b0);
    push_one(7, 8'hA1, 1'b0, 1'b0);
    for (int i = 0; i < 63; i++) begin
      read_word(w);
      if (w !== exp_word(0, 0, 0, 3'(i % 8), 8'(i))) bad++;
    end
    chk("R3 full queue order", 32'(bad), 32'h0);
    read_word(w);
    chk("R6 newest replaced", 32'(w), 32'(exp_word(1, 0, 0, 3'd7, 8'hA1)));
    chk("R6 depth limit", 32'(rd_data), 32'h0);
  endtask

  task automatic t_alarm;
    logic [15:0] w;
    @(negedge clk);
    alarm_en = 1'b1;
    rie = 1'b1;
    for (int i = 0; i < 15; i++) push_one(i % 8, 8'(i), 1'b0, 1'b0);
    chk("R7 no alarm at 15", 32'(alarm), 32'h0);
    chk("R10 irq follows alarm", 32'(rx_irq), 32'h0);
    push_one(0, 8'hF0, 1'b0, 1'b0);
    chk("R7 alarm at 16", 32'(alarm), 32'h1);
    chk("R10 irq on alarm", 32'(rx_irq), 32'h1);
    read_word(w);
    chk("R8 read clears alarm", 32'(alarm), 32'h0);
    for (int i = 0; i < 15; i++) push_one(1, 8'(i), 1'b0, 1'b0);
    chk("R8 no early re-alarm", 32'(alarm), 32'h0);
    push_one(2, 8'hEE, 1'b0, 1'b0);
    chk("R8 re-alarm at 16", 32'(alarm), 32'h1);
    @(negedge clk);
    alarm_en = 1'b0;
    @(negedge clk);
    chk("R8 disable clears", 32'(alarm), 32'h0);
    chk("R10 irq by done", 32'(rx_irq), 32'h1);
    rie = 1'b0;
    #1 chk("R10 irq needs rie", 32'(rx_irq), 32'h0);
    pulse_clear(1'b0);
    chk("R11 ctrl clear empties", 32'(rx_done), 32'h0);
    chk("R11 ctrl clear word", 32'(rd_data), 32'h0);
  endtask

  task automatic t_init;
    logic [15:0] w;
    push_one(5, 8'h01, 1'b0, 1'b0);
    push_one(5, 8'h02, 1'b0, 1'b0);
    pulse_clear(1'b1);
    chk("R11 bus init empties", 32'(rx_done), 32'h0);
    push_one(4, 8'h44, 1'b0, 1'b0);
    read_word(w);
    chk("R11 clean after init", 32'(w), 32'(exp_word(0, 0, 0, 3'd4, 8'h44)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_init = 1'b0; ctrl_clr = 1'b0; scan_en = 1'b1;
    alarm_en = 1'b0; rie = 1'b0; rd_stb = 1'b0;
    rx_valid = '0; rx_frm = '0; rx_par = '0; rx_char = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_empty_read();
    t_scan_off();
    t_arb();
    t_overflow();
    t_alarm();
    t_init();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule